// File: doc/BRIEF.md
# Compacting Operand-Snooping Scheduler

This block is the issue queue for renamed floating-point operations. Each cycle it takes up to three new operations in age order. Every operation carries a destination tag and up to three source tags, and each source has a ready bit. The queue holds up to 36 operations, kept packed so that position 0 is always the oldest.

Each source watches exactly one group of tag buses, chosen when the operation is inserted. The group is either the three result buses or the two load-data buses, so a source never compares against more than three tags. An operation becomes eligible once all of its sources are ready. It leaves the queue when the oldest eligible operation for its execution pipe is picked and that pipe is free. The surviving operations then close up toward position 0.

A full flag holds off the dispatcher whenever fewer than three slots are free. A flush empties the queue in one cycle.

Top module: `fpSched`

## Requirements
- R1: After reset the queue is empty: `issueValid` is all zero and `full` is low.
- R2: An entry issues on pipe p only when all three of its ready bits are set and `pipeFree[p]` is high. Issue is combinational from the stored state, and the issued entry is removed at the next clock edge.
- R3: Pipe encoding: 0 is add, 1 is multiply, 2 is store. On each pipe the oldest eligible entry is picked, and at most one entry issues per pipe per cycle. Different pipes may issue in the same cycle. An older entry that is not ready does not block a younger ready one. Within one insert cycle, slot 0 is older than slot 1, and slot 1 is older than slot 2.
- R4: A source whose group bit is 0 is woken only by `resTag` buses. A source whose group bit is 1 is woken only by `ldTag` buses. Because of this, an operation that waits on load data cannot issue before that load tag arrives.
- R5: A matching valid tag on a snooped bus in cycle t sets the ready bit at the edge that ends cycle t. The entry can issue, at the earliest, in cycle t+1. It is not eligible during cycle t itself.
- R6: A tag on a snooped bus in the same cycle as the insertion marks that source ready at once. If the operation is otherwise ready, it is eligible in the very next cycle.
- R7: The queue holds 36 entries. Entries that are not issued keep their relative age after other entries are removed, and every entry accepted is issued exactly once.
- R8: `full` is high whenever more than 33 entries are held. All insert slots are ignored while `full` is high.
- R9: `flush` suppresses all issue in its cycle, drops any inserts presented in that cycle, and leaves the queue empty at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Discard every held entry |
| insValid | input | 3 | Insert slot valid, slot 0 oldest |
| insPipe | input | 3x2 | Target pipe per slot (0 add, 1 mul, 2 store) |
| insDst | input | 3x7 | Destination tag per slot |
| insSrcTag | input | 3x3x7 | Source tags per slot |
| insSrcRdy | input | 3x3 | Source already ready (set for unused sources) |
| insSrcGrp | input | 3x3 | Bus group per source: 0 result, 1 load |
| resValid | input | 3 | Result bus valid |
| resTag | input | 3x7 | Result bus tags |
| ldValid | input | 2 | Load-data bus valid |
| ldTag | input | 2x7 | Load-data bus tags |
| pipeFree | input | 3 | Pipe can accept an operation this cycle |
| full | output | 1 | Fewer than three free slots; stall dispatch |
| issueValid | output | 3 | Operation issued on each pipe |
| issueDst | output | 3x7 | Destination tag of each issued operation |

## Verification
The bench sets up the following cases:
- A source waiting on a load tag is shown the same tag on a result bus, and the reverse. A design that snooped both groups would issue early.
- Wake timing is probed both in the bus cycle and one cycle after it. A same-cycle insert-and-broadcast case is also run. A design with an off-by-one ready path would issue a cycle early or miss the insert-time match and wait forever.
- The queue is filled to 36 entries, inserts are pushed while it is full, and it is drained one entry per cycle with the destination sequence checked. A compaction bug would reorder or duplicate entries, and a leaky full gate would add extra issues.
- A flush with a simultaneous insert confirms that nothing survives.

// File: rtl/fpSchedPkg.sv
package fpSchedPkg;
  localparam int SCHED_DEPTH = 36;
  localparam int TAG_W = 7;
  localparam int NSRC = 3;
  localparam int NPIPE = 3;
  localparam int PIPE_W = $clog2(NPIPE);

  typedef struct packed {
    logic                       valid;
    logic [PIPE_W-1:0]          pipe;
    logic [TAG_W-1:0]           dst;
    logic [NSRC-1:0][TAG_W-1:0] src;
    logic [NSRC-1:0]            rdy;
    logic [NSRC-1:0]            grp;
  } schedEnt_t;

  typedef struct packed {
    logic [SCHED_DEPTH-1:0] issueMask;
    logic                   acceptIns;
    logic                   flush;
  } schedStrobe_t;
endpackage

// File: rtl/schedData.sv
module schedData
  import fpSchedPkg::*;
#(
  parameter int DEPTH = SCHED_DEPTH,
  parameter int INS_W = 3,
  parameter int NRES = 3,
  parameter int NLOAD = 2
) (
  input  logic                                   clk,
  input  logic                                   rstN,
  input  schedStrobe_t                           strobe,
  input  logic [INS_W-1:0]                       insValid,
  input  logic [INS_W-1:0][PIPE_W-1:0]           insPipe,
  input  logic [INS_W-1:0][TAG_W-1:0]            insDst,
  input  logic [INS_W-1:0][NSRC-1:0][TAG_W-1:0]  insSrcTag,
  input  logic [INS_W-1:0][NSRC-1:0]             insSrcRdy,
  input  logic [INS_W-1:0][NSRC-1:0]             insSrcGrp,
  input  logic [NRES-1:0]                        resValid,
  input  logic [NRES-1:0][TAG_W-1:0]             resTag,
  input  logic [NLOAD-1:0]                       ldValid,
  input  logic [NLOAD-1:0][TAG_W-1:0]            ldTag,
  output logic [DEPTH-1:0]                       entValid,
  output logic [DEPTH-1:0]                       entWake,
  output logic [DEPTH-1:0][PIPE_W-1:0]           entPipe,
  output logic [DEPTH-1:0][TAG_W-1:0]            entDst
);
  schedEnt_t [DEPTH-1:0] ent;
  schedEnt_t [DEPTH-1:0] nxt;

  // A source compares only against the bus group fixed at insertion.
  function automatic logic snoop(input logic [TAG_W-1:0] t, input logic g);
    logic hit;
    hit = 1'b0;
    if (g) begin
      for (int b = 0; b < NLOAD; b++) if (ldValid[b] && ldTag[b] == t) hit = 1'b1;
    end else begin
      for (int b = 0; b < NRES; b++) if (resValid[b] && resTag[b] == t) hit = 1'b1;
    end
    return hit;
  endfunction

  always_comb begin
    int pos;
    schedEnt_t e;
    nxt = '0;
    pos = 0;
    e = '0;
    if (!strobe.flush) begin
      // Keep survivors in age order, packed toward position 0.
      for (int i = 0; i < DEPTH; i++) begin
        if (ent[i].valid && !strobe.issueMask[i]) begin
          if (pos < DEPTH) nxt[pos] = ent[i];
          pos++;
        end
      end
      if (strobe.acceptIns) begin
        for (int k = 0; k < INS_W; k++) begin
          if (insValid[k]) begin
            e.valid = 1'b1;
            e.pipe  = insPipe[k];
            e.dst   = insDst[k];
            e.src   = insSrcTag[k];
            e.rdy   = insSrcRdy[k];
            e.grp   = insSrcGrp[k];
            if (pos < DEPTH) nxt[pos] = e;
            pos++;
          end
        end
      end
      for (int j = 0; j < DEPTH; j++) begin
        for (int s = 0; s < NSRC; s++) begin
          if (nxt[j].valid && !nxt[j].rdy[s] && snoop(nxt[j].src[s], nxt[j].grp[s]))
            nxt[j].rdy[s] = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) ent <= '0;
    else       ent <= nxt;
  end

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      entValid[i] = ent[i].valid;
      entWake[i]  = ent[i].valid && (&ent[i].rdy);
      entPipe[i]  = ent[i].pipe;
      entDst[i]   = ent[i].dst;
    end
  end

  AST_COMPACT_PACKED: assert property (@(posedge clk) disable iff (!rstN)
    ((entValid + 1'b1) & entValid) == '0) else $error("holes in queue"); // R7

  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    strobe.flush |=> entValid == '0) else $error("flush left entries"); // R9
endmodule

// File: rtl/schedCtrl.sv
module schedCtrl
  import fpSchedPkg::*;
#(
  parameter int DEPTH = SCHED_DEPTH,
  parameter int INS_W = 3,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          flush,
  input  logic [INS_W-1:0]              insValid,
  input  logic [NPIPE-1:0]              pipeFree,
  input  logic [DEPTH-1:0]              entValid,
  input  logic [DEPTH-1:0]              entWake,
  input  logic [DEPTH-1:0][PIPE_W-1:0]  entPipe,
  input  logic [DEPTH-1:0][TAG_W-1:0]   entDst,
  output schedStrobe_t                  strobe,
  output logic                          full,
  output logic [NPIPE-1:0]              issueValid,
  output logic [NPIPE-1:0][TAG_W-1:0]   issueDst
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] nIns;
  logic [CNT_W-1:0] nIss;
  logic [DEPTH-1:0] mask;

  assign full = cnt > CNT_W'(DEPTH - INS_W);

  // Oldest-first pick per pipe: first eligible position wins.
  always_comb begin
    logic found;
    mask = '0;
    issueValid = '0;
    issueDst = '0;
    for (int p = 0; p < NPIPE; p++) begin
      found = 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
        if (!found && !flush && pipeFree[p] && entWake[i] && entPipe[i] == PIPE_W'(p)) begin
          found = 1'b1;
          mask[i] = 1'b1;
          issueValid[p] = 1'b1;
          issueDst[p] = entDst[i];
        end
      end
    end
  end

  always_comb begin
    strobe.issueMask = mask;
    strobe.acceptIns = !full && !flush;
    strobe.flush     = flush;
    nIns = strobe.acceptIns ? CNT_W'($countones(insValid)) : '0;
    nIss = CNT_W'($countones(mask));
  end

  always_ff @(posedge clk) begin
    if (!rstN)      cnt <= '0;
    else if (flush) cnt <= '0;
    else            cnt <= cnt - nIss + nIns;
  end

  AST_COUNT_TRACK: assert property (@(posedge clk) disable iff (!rstN)
    cnt == CNT_W'($countones(entValid))) else $error("count mismatch"); // R7

  AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    full |=> cnt <= $past(cnt)) else $error("insert while full"); // R8

  for (genvar gp = 0; gp < NPIPE; gp++) begin : gPipeChk
    AST_PIPE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
      !pipeFree[gp] |-> !issueValid[gp]) else $error("issue to busy pipe"); // R2
  end
endmodule

// File: rtl/fpSched.sv
module fpSched
  import fpSchedPkg::*;
#(
  parameter int INS_W = 3,
  parameter int NRES = 3,
  parameter int NLOAD = 2
) (
  input  logic                                   clk,
  input  logic                                   rstN,
  input  logic                                   flush,
  input  logic [INS_W-1:0]                       insValid,
  input  logic [INS_W-1:0][PIPE_W-1:0]           insPipe,
  input  logic [INS_W-1:0][TAG_W-1:0]            insDst,
  input  logic [INS_W-1:0][NSRC-1:0][TAG_W-1:0]  insSrcTag,
  input  logic [INS_W-1:0][NSRC-1:0]             insSrcRdy,
  input  logic [INS_W-1:0][NSRC-1:0]             insSrcGrp,
  input  logic [NRES-1:0]                        resValid,
  input  logic [NRES-1:0][TAG_W-1:0]             resTag,
  input  logic [NLOAD-1:0]                       ldValid,
  input  logic [NLOAD-1:0][TAG_W-1:0]            ldTag,
  input  logic [NPIPE-1:0]                       pipeFree,
  output logic                                   full,
  output logic [NPIPE-1:0]                       issueValid,
  output logic [NPIPE-1:0][TAG_W-1:0]            issueDst
);
  localparam int DEPTH = SCHED_DEPTH;

  schedStrobe_t                 strobe;
  logic [DEPTH-1:0]             entValid;
  logic [DEPTH-1:0]             entWake;
  logic [DEPTH-1:0][PIPE_W-1:0] entPipe;
  logic [DEPTH-1:0][TAG_W-1:0]  entDst;

  schedCtrl #(.DEPTH(DEPTH), .INS_W(INS_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .flush(flush), .insValid(insValid), .pipeFree(pipeFree),
    .entValid(entValid), .entWake(entWake), .entPipe(entPipe), .entDst(entDst),
    .strobe(strobe), .full(full), .issueValid(issueValid), .issueDst(issueDst)
  );

  schedData #(.DEPTH(DEPTH), .INS_W(INS_W), .NRES(NRES), .NLOAD(NLOAD)) data_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .insValid(insValid), .insPipe(insPipe),
    .insDst(insDst), .insSrcTag(insSrcTag), .insSrcRdy(insSrcRdy), .insSrcGrp(insSrcGrp),
    .resValid(resValid), .resTag(resTag), .ldValid(ldValid), .ldTag(ldTag),
    .entValid(entValid), .entWake(entWake), .entPipe(entPipe), .entDst(entDst)
  );
endmodule

// File: tb/fpSched_tb.sv
module fpSched_tb_top;
  import fpSchedPkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic flush = 1'b0;
  logic [2:0] insValid;
  logic [2:0][PIPE_W-1:0] insPipe;
  logic [2:0][TAG_W-1:0] insDst;
  logic [2:0][NSRC-1:0][TAG_W-1:0] insSrcTag;
  logic [2:0][NSRC-1:0] insSrcRdy;
  logic [2:0][NSRC-1:0] insSrcGrp;
  logic [2:0] resValid;
  logic [2:0][TAG_W-1:0] resTag;
  logic [1:0] ldValid;
  logic [1:0][TAG_W-1:0] ldTag;
  logic [2:0] pipeFree;
  logic full;
  logic [2:0] issueValid;
  logic [2:0][TAG_W-1:0] issueDst;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  fpSched dut_i (
    .clk(clk), .rstN(rstN), .flush(flush), .insValid(insValid), .insPipe(insPipe),
    .insDst(insDst), .insSrcTag(insSrcTag), .insSrcRdy(insSrcRdy), .insSrcGrp(insSrcGrp),
    .resValid(resValid), .resTag(resTag), .ldValid(ldValid), .ldTag(ldTag),
    .pipeFree(pipeFree), .full(full), .issueValid(issueValid), .issueDst(issueDst)
  );

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clearIns();
    insValid = '0; insPipe = '0; insDst = '0; insSrcTag = '0;
    insSrcRdy = '0; insSrcGrp = '0; resValid = '0; resTag = '0;
    ldValid = '0; ldTag = '0;
  endtask

  task automatic setIns(input int k, input int pipe, input int dst,
                        input int tag0, input bit rdy0, input bit grp0);
    insValid[k] = 1'b1;
    insPipe[k] = PIPE_W'(pipe);
    insDst[k] = TAG_W'(dst);
    insSrcTag[k] = '0;
    insSrcTag[k][0] = TAG_W'(tag0);
    insSrcRdy[k] = {2'b11, rdy0};
    insSrcGrp[k] = {2'b00, grp0};
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    clearIns();
    pipeFree = '0;
    repeat (3) tick();
    rstN = 1'b1;
    #1;
    chk("R1 issue after reset", issueValid, 0);
    chk("R1 full after reset", full, 0);

    // R2: ready op held while pipe busy, issues once free
    setIns(0, 0, 10, 0, 1, 0);
    tick(); clearIns(); #1;
    chk("R2 busy pipe blocks", issueValid, 0);
    pipeFree = 3'b001; #1;
    chk("R2 free pipe issues", issueValid[0], 1);
    chk("R2 issued dst", issueDst[0], 10);
    tick(); #1;
    chk("R7 issued entry removed", issueValid, 0);

    // R5: result-bus wakeup timing
    setIns(0, 0, 11, 5, 0, 0);
    tick(); clearIns(); #1;
    chk("R2 unready source blocks", issueValid[0], 0);
    resValid[1] = 1'b1; resTag[1] = 7'd5; #1;
    chk("R5 not eligible in bus cycle", issueValid[0], 0);
    tick(); clearIns(); #1;
    chk("R5 eligible after bus cycle", issueValid[0], 1);
    chk("R5 dst", issueDst[0], 11);
    tick();

    // R4: load-group source ignores result buses
    setIns(0, 0, 12, 6, 0, 1);
    tick(); clearIns();
    resValid[0] = 1'b1; resTag[0] = 7'd6;
    tick(); clearIns(); #1;
    chk("R4 load source ignores result bus", issueValid[0], 0);
    ldValid[1] = 1'b1; ldTag[1] = 7'd6;
    tick(); clearIns(); #1;
    chk("R4 load data wakes", issueValid[0], 1);
    chk("R4 dst", issueDst[0], 12);
    tick();

    // R4: result-group source ignores load buses
    setIns(0, 0, 13, 8, 0, 0);
    tick(); clearIns();
    ldValid[0] = 1'b1; ldTag[0] = 7'd8;
    tick(); clearIns(); #1;
    chk("R4 result source ignores load bus", issueValid[0], 0);
    resValid[2] = 1'b1; resTag[2] = 7'd8;
    tick(); clearIns(); #1;
    chk("R4 result bus wakes", issueDst[0], 13);
    chk("R4 result bus wakes valid", issueValid[0], 1);
    tick();

    // R6: same-cycle insert and broadcast
    setIns(0, 0, 14, 7, 0, 0);
    resValid[2] = 1'b1; resTag[2] = 7'd7;
    tick(); clearIns(); #1;
    chk("R6 same-cycle result match", issueValid[0], 1);
    chk("R6 dst", issueDst[0], 14);
    tick();
    setIns(0, 0, 15, 9, 0, 1);
    ldValid[0] = 1'b1; ldTag[0] = 7'd9;
    tick(); clearIns(); #1;
    chk("R6 same-cycle load match", issueDst[0], 15);
    tick();

    // R3: oldest first, one per pipe, pipes in parallel
    pipeFree = '0;
    setIns(0, 1, 20, 0, 1, 0); setIns(1, 1, 21, 0, 1, 0); setIns(2, 1, 22, 0, 1, 0);
    tick(); clearIns();
    setIns(0, 0, 30, 0, 1, 0); setIns(1, 2, 31, 0, 1, 0);
    tick(); clearIns();
    pipeFree = 3'b111; #1;
    chk("R3 three pipes issue", issueValid, 7);
    chk("R3 mul oldest", issueDst[1], 20);
    chk("R3 add dst", issueDst[0], 30);
    chk("R3 store dst", issueDst[2], 31);
    tick(); #1;
    chk("R3 mul next", issueDst[1], 21);
    chk("R3 only mul left", issueValid, 2);
    tick(); #1;
    chk("R3 mul last", issueDst[1], 22);
    tick(); #1;
    chk("R3 drained", issueValid, 0);

    // R3: unready older entry does not block younger
    pipeFree = 3'b010;
    setIns(0, 1, 40, 50, 0, 0); setIns(1, 1, 41, 0, 1, 0);
    tick(); clearIns(); #1;
    chk("R3 younger ready bypasses", issueDst[1], 41);
    tick(); #1;
    chk("R3 older still waits", issueValid[1], 0);
    resValid[0] = 1'b1; resTag[0] = 7'd50;
    tick(); clearIns(); #1;
    chk("R3 older then issues", issueDst[1], 40);
    tick();

    // R7/R8: fill to capacity, push while full, drain in order
    pipeFree = '0;
    for (int c = 0; c < 12; c++) begin
      for (int k = 0; k < 3; k++) setIns(k, 0, 3 * c + k, 0, 1, 0);
      tick(); clearIns(); #1;
      if (c == 10) chk("R8 not full at 33", full, 0);
      if (c == 11) chk("R8 full at 36", full, 1);
    end
    for (int k = 0; k < 3; k++) setIns(k, 0, 100 + k, 0, 1, 0);
    tick(); clearIns(); #1;
    chk("R8 still full after blocked insert", full, 1);
    pipeFree = 3'b001;
    for (int n = 0; n < 36; n++) begin
      #1;
      chk("R7 drain valid", issueValid[0], 1);
      chk("R7 drain order", issueDst[0], n);
      chk("R8 full level", full, (36 - n > 33) ? 1 : 0);
      tick();
    end
    #1;
    chk("R8 blocked inserts dropped", issueValid, 0);

    // R9: flush
    pipeFree = '0;
    setIns(0, 0, 60, 0, 1, 0); setIns(1, 0, 61, 0, 1, 0);
    tick(); clearIns();
    flush = 1'b1;
    setIns(0, 0, 62, 0, 1, 0);
    pipeFree = 3'b111; #1;
    chk("R9 no issue in flush cycle", issueValid, 0);
    tick(); flush = 1'b0; clearIns(); #1;
    chk("R9 empty after flush", issueValid, 0);
    chk("R9 not full after flush", full, 0);
    tick(); #1;
    chk("R9 flush insert dropped", issueValid, 0);

    summary();
    $finish;
  end
endmodule